// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Atomic Control Aliases

The block drives several independent pulse-width modulated outputs from a single clock. Each channel has its own output pin value and output-enable. A small memory-mapped bus reaches one shared enable register and two configuration registers per channel. The enable register can be written whole. Three alias addresses also act on it: one ORs the written data into the register, one clears the bits that are set in the data, and one inverts those bits. Software can therefore start or stop one channel without a read-modify-write.

Each channel divides the clock by a power of two and counts prescaled ticks through a programmable period. Inside each period the output is in its active phase from a start count up to, but not including, a duty count. It is in its inactive phase the rest of the time. Each phase has its own programmable level: drive high, drive low, or released. Register writes land in shadow copies. A running channel takes the new values only when a period ends, so a half-updated setting never produces a stray pulse. A stopped channel follows its shadow copies directly.

Top module: `multi_pwm`

## Requirements
- R1: After reset the enable register and all shadow registers read 0, every channel is stopped, and every channel shows pin 0 with output-enable 0.
- R2: A write at byte address 0x0 replaces the enable register with the data's low NUM_CH bits. Reads at 0x0, 0x4, 0x8 and 0xC return the enable register in the low NUM_CH bits, and the higher bits read 0. Bit n of the enable register runs channel n.
- R3: A write at 0x4 ORs the data into the enable register. A write at 0x8 clears the bits that are 1 in the data. A write at 0xC inverts the bits that are 1 in the data.
- R4: Channel n's window register sits at 0x10+0x20·n and its period register at 0x20+0x20·n. Both read back their shadow values. Period register bits 31:23 are not stored and read 0. A write to any other address changes nothing.
- R5: Period bits 22:20 hold a value k. A running channel's counter advances once every 2^k clocks.
- R6: Period bits 15:0 hold P. The counter runs 0..P-1, and the period ends on the tick where the counter would reach P. A P of 0 behaves like a P of 1.
- R7: Window bits 15:0 hold the start count S and bits 31:16 hold the duty count D. A running channel is in its active phase when S ≤ count < D.
- R8: When D ≥ P and D is not 0, the channel is active for the whole period. When D = 0, it is never active.
- R9: Period bits 17:16 select the active-phase level and bits 19:18 the inactive-phase level. Code 3 drives pin 1 with output-enable 1, code 2 drives pin 0 with output-enable 1, and codes 0 and 1 give pin 0 with output-enable 0.
- R10: While a channel runs, its working settings load from the shadow registers only on the clock edge that ends a period. Writes made earlier in the period have no effect on the output until then.
- R11: A stopped channel holds its counter and prescaler at 0, shows its inactive-phase level, and loads its working settings from the shadow registers one clock after they are written. Once enabled, a channel starts counting at the beginning of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write strobe, one clock per write |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pwmPin | output | NUM_CH | Pin value per channel |
| pwmOe | output | NUM_CH | Output-enable per channel |

## Verification
The hardest case to reach is a configuration write that lands in the middle of a running period. The output must keep the old setting until the exact tick that ends the period, and that tick depends on the prescaler phase as well as the counter. The bench reaches this case by rewriting the period and window registers of channels that are already running with different prescaler values. A behavioural model tracks every channel's counter, prescaler, shadow and working copies on every clock. Disabling channels through the clear alias, rewriting them while stopped and re-enabling them through the set alias also exercises the immediate-load path and the restart at a period boundary.

// File: rtl/multi_pwm_pkg.sv
package multi_pwm_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int LVL_W  = 2;
  localparam int PRE_W  = 3;
  localparam int DIV_W  = (1 << PRE_W) - 1;
  localparam int PER_W  = CNT_W + 2 * LVL_W + PRE_W;

  // Bit positions inside the period word
  localparam int ACT_LVL_LSB = CNT_W;
  localparam int IDL_LVL_LSB = CNT_W + LVL_W;
  localparam int PRE_LSB     = CNT_W + 2 * LVL_W;

  // Control path to datapath: run strobe plus shadow contents per channel
  typedef struct packed {
    logic              run;
    logic [DATA_W-1:0] winWord;
    logic [PER_W-1:0]  perWord;
  } chanCfg_t;
endpackage

// File: rtl/multi_pwm_ctrl.sv
module multi_pwm_ctrl
  import multi_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  output chanCfg_t [NUM_CH-1:0]         cfgO
);
  localparam int IDX_W = ADDR_W - 5;

  logic [NUM_CH-1:0] enReg;
  logic [DATA_W-1:0] winShadow [NUM_CH];
  logic [PER_W-1:0]  perShadow [NUM_CH];

  logic             isCtrl, isWin, isPer;
  logic [1:0]       ctrlOp;
  logic [IDX_W-1:0] chanIdx;

  always_comb begin
    chanIdx = busAddr[ADDR_W-1:5];
    ctrlOp  = busAddr[3:2];
    isCtrl  = (busAddr[ADDR_W-1:4] == '0) && (busAddr[1:0] == 2'b00);
    isWin   = busAddr[4] && (busAddr[3:0] == 4'h0) && (int'(chanIdx) < NUM_CH);
    isPer   = !busAddr[4] && (busAddr[3:0] == 4'h0) && (chanIdx != '0) &&
              (int'(chanIdx) <= NUM_CH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0;
    end else if (busWe && isCtrl) begin
      case (ctrlOp)
        2'd0: enReg <= busWdata[NUM_CH-1:0];
        2'd1: enReg <= enReg | busWdata[NUM_CH-1:0];
        2'd2: enReg <= enReg & ~busWdata[NUM_CH-1:0];
        default: enReg <= enReg ^ busWdata[NUM_CH-1:0];
      endcase
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : gShadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winShadow[n] <= '0;
        perShadow[n] <= '0;
      end else if (busWe) begin
        if (isWin && int'(chanIdx) == n) winShadow[n] <= busWdata;
        if (isPer && int'(chanIdx) == n + 1) perShadow[n] <= busWdata[PER_W-1:0];
      end
    end
    assign cfgO[n].run     = enReg[n];
    assign cfgO[n].winWord = winShadow[n];
    assign cfgO[n].perWord = perShadow[n];
  end

  always_comb begin
    busRdata = '0;
    if (isCtrl) busRdata[NUM_CH-1:0] = enReg;
    for (int i = 0; i < NUM_CH; i++) begin
      if (isWin && int'(chanIdx) == i) busRdata = winShadow[i];
      if (isPer && int'(chanIdx) == i + 1) busRdata = {{(DATA_W-PER_W){1'b0}}, perShadow[i]};
    end
  end

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isCtrl && ctrlOp == 2'd1) |=> enReg == ($past(enReg) | $past(busWdata[NUM_CH-1:0]))); // R3
  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isCtrl && ctrlOp == 2'd2) |=> (enReg & $past(busWdata[NUM_CH-1:0])) == '0); // R3
  AST_TOG_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isCtrl && ctrlOp == 2'd3) |=> enReg == ($past(enReg) ^ $past(busWdata[NUM_CH-1:0]))); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && isCtrl) |=> $stable(enReg)); // R2
endmodule

// File: rtl/multi_pwm_chan.sv
module multi_pwm_chan
  import multi_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCfg_t cfgI,
  output logic     pinO,
  output logic     oeO
);
  logic [CNT_W-1:0] wStart, wDuty, wPer, cnt;
  logic [LVL_W-1:0] wActLvl, wIdlLvl, lvl;
  logic [PRE_W-1:0] wPre;
  logic [DIV_W-1:0] pre, preLimit;
  logic             tick, last, rollEvent, inWindow, active;

  always_comb begin
    preLimit  = DIV_W'((DIV_W+1)'(1) << wPre) - DIV_W'(1);
    tick      = (pre == preLimit);
    last      = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, wPer};
    rollEvent = cfgI.run && tick && last;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0; pre <= '0;
      wStart <= '0; wDuty <= '0; wPer <= '0;
      wActLvl <= '0; wIdlLvl <= '0; wPre <= '0;
    end else begin
      if (!cfgI.run) begin
        cnt <= '0;
        pre <= '0;
      end else if (tick) begin
        pre <= '0;
        cnt <= last ? '0 : cnt + CNT_W'(1);
      end else begin
        pre <= pre + DIV_W'(1);
      end
      if (!cfgI.run || rollEvent) begin
        wStart  <= cfgI.winWord[CNT_W-1:0];
        wDuty   <= cfgI.winWord[DATA_W-1:CNT_W];
        wPer    <= cfgI.perWord[CNT_W-1:0];
        wActLvl <= cfgI.perWord[ACT_LVL_LSB +: LVL_W];
        wIdlLvl <= cfgI.perWord[IDL_LVL_LSB +: LVL_W];
        wPre    <= cfgI.perWord[PRE_LSB +: PRE_W];
      end
    end
  end

  always_comb begin
    inWindow = (cnt >= wStart) && (cnt < wDuty);
    active   = cfgI.run && (wDuty != '0) && ((wDuty >= wPer) || inWindow);
    lvl      = active ? wActLvl : wIdlLvl;
    pinO     = (lvl == 2'b11);
    oeO      = lvl[1];
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfgI.run |=> (cnt == '0 && pre == '0)); // R11
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgI.run && wPer != '0) |-> cnt < wPer); // R6
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cfgI.run |-> pre <= preLimit); // R5
  AST_HOLD_WORKING: assert property (@(posedge clk) disable iff (!rstN)
    (cfgI.run && !rollEvent) |=> ($stable(wPer) && $stable(wDuty) && $stable(wStart))); // R10
endmodule

// File: rtl/multi_pwm_dp.sv
module multi_pwm_dp
  import multi_pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chanCfg_t [NUM_CH-1:0] cfgI,
  output logic [NUM_CH-1:0]     pinO,
  output logic [NUM_CH-1:0]     oeO
);
  for (genvar n = 0; n < NUM_CH; n++) begin : gChan
    multi_pwm_chan chan_i (
      .clk  (clk),
      .rstN (rstN),
      .cfgI (cfgI[n]),
      .pinO (pinO[n]),
      .oeO  (oeO[n])
    );
  end
endmodule

// File: rtl/multi_pwm.sv
module multi_pwm
  import multi_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] pwmPin,
  output logic [NUM_CH-1:0] pwmOe
);
  chanCfg_t [NUM_CH-1:0] cfg;

  multi_pwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .cfgO     (cfg)
  );

  multi_pwm_dp #(.NUM_CH(NUM_CH)) dp_i (
    .clk  (clk),
    .rstN (rstN),
    .cfgI (cfg),
    .pinO (pwmPin),
    .oeO  (pwmOe)
  );
endmodule

// File: tb/multi_pwm_tb_top.sv
module multi_pwm_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NCH-1:0] pwmPin, pwmOe;

  always #5 clk = ~clk;

  multi_pwm #(.NUM_CH(NCH), .ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmPin(pwmPin), .pwmOe(pwmOe)
  );

  int nChecks = 0, nFail = 0;
  bit compareOn = 0;
  string curReq = "R1";

  // Behavioural reference state
  int mCtrl;
  int sWin[NCH], sPer[NCH];
  int wSt[NCH], wDu[NCH], wPe[NCH], wAl[NCH], wIl[NCH], wK[NCH];
  int mCnt[NCH], mPre[NCH];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void loadWork(int c);
    wSt[c] = sWin[c] & 32'hFFFF;
    wDu[c] = (sWin[c] >> 16) & 32'hFFFF;
    wPe[c] = sPer[c] & 32'hFFFF;
    wAl[c] = (sPer[c] >> 16) & 3;
    wIl[c] = (sPer[c] >> 18) & 3;
    wK[c]  = (sPer[c] >> 20) & 7;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = 0;
      for (int c = 0; c < NCH; c++) begin
        sWin[c] = 0; sPer[c] = 0; mCnt[c] = 0; mPre[c] = 0; loadWork(c);
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (((mCtrl >> c) & 1) == 0) begin
          mCnt[c] = 0; mPre[c] = 0; loadWork(c);
        end else if (mPre[c] == (1 << wK[c]) - 1) begin
          mPre[c] = 0;
          if (mCnt[c] + 1 >= wPe[c]) begin
            mCnt[c] = 0; loadWork(c);
          end else mCnt[c]++;
        end else mPre[c]++;
      end
      if (busWe) begin
        int a, d;
        a = int'(busAddr); d = int'(busWdata);
        if (a < 16 && a % 4 == 0) begin
          case (a / 4)
            0: mCtrl = d & 32'hF;
            1: mCtrl = mCtrl | (d & 32'hF);
            2: mCtrl = mCtrl & ~d & 32'hF;
            default: mCtrl = (mCtrl ^ d) & 32'hF;
          endcase
        end else if (a % 32 == 16 && a / 32 < NCH) sWin[a / 32] = d;
        else if (a % 32 == 0 && a >= 32 && a / 32 - 1 < NCH) sPer[a / 32 - 1] = d & 32'h7FFFFF;
      end
    end
  end

  function automatic int expLvl(int c);
    bit act;
    act = (((mCtrl >> c) & 1) == 1) && (wDu[c] != 0) &&
          ((wDu[c] >= wPe[c]) || (mCnt[c] >= wSt[c] && mCnt[c] < wDu[c]));
    return act ? wAl[c] : wIl[c];
  endfunction

  always @(negedge clk) begin
    if (rstN && compareOn) begin
      for (int c = 0; c < NCH; c++) begin
        int l;
        l = expLvl(c);
        chk({curReq, " pin"}, 32'(pwmPin[c]), 32'(l == 3));
        chk({curReq, " oe"}, 32'(pwmOe[c]), 32'(l >= 2));
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(logic [7:0] a, logic [31:0] exp, string tag);
    busAddr = a;
    #1;
    chk(tag, busRdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] perW(int p, int al, int il, int k);
    return 32'(p | (al << 16) | (il << 18) | (k << 20));
  endfunction

  function automatic logic [31:0] winW(int s, int d);
    return 32'((d << 16) | s);
  endfunction

  initial begin
    #1_500_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 pin", 32'(pwmPin), 32'h0);
    chk("R1 oe", 32'(pwmOe), 32'h0);
    rdChk(8'h00, 32'h0, "R1 ctrl");
    rdChk(8'h10, 32'h0, "R1 win0");
    rdChk(8'h80, 32'h0, "R1 per3");
    idle(1);
    compareOn = 1;

    curReq = "R4";
    wr(8'h10, winW(2, 5));
    wr(8'h20, perW(10, 3, 2, 0));
    rdChk(8'h10, winW(2, 5), "R4 win0");
    rdChk(8'h20, perW(10, 3, 2, 0), "R4 per0");
    wr(8'h14, 32'h1234_5678);
    rdChk(8'h10, winW(2, 5), "R4 unmapped");
    wr(8'h40, 32'hFFFF_FFFF);
    rdChk(8'h40, 32'h007F_FFFF, "R4 per1 mask");

    curReq = "R2";
    wr(8'h00, 32'hFF);
    rdChk(8'h00, 32'hF, "R2 ctrl mask");
    wr(8'h00, 32'h1);
    rdChk(8'h0C, 32'h1, "R2 alias read");
    curReq = "R7";
    idle(40);

    curReq = "R3";
    wr(8'h04, 32'h2); rdChk(8'h00, 32'h3, "R3 set");
    wr(8'h08, 32'h1); rdChk(8'h00, 32'h2, "R3 clear");
    wr(8'h0C, 32'h5); rdChk(8'h00, 32'h7, "R3 toggle");
    wr(8'h08, 32'hF); rdChk(8'h00, 32'h0, "R3 clear all");

    curReq = "R8";
    wr(8'h30, winW(0, 20)); wr(8'h40, perW(8, 3, 2, 0));
    wr(8'h50, winW(1, 3));  wr(8'h60, perW(5, 3, 2, 3));
    wr(8'h70, winW(0, 0));  wr(8'h80, perW(6, 3, 2, 1));
    wr(8'h00, 32'hF);
    idle(30);
    curReq = "R5";
    idle(100);

    curReq = "R10";
    idle(7);
    wr(8'h60, perW(4, 2, 3, 2));
    wr(8'h50, winW(0, 2));
    wr(8'h80, perW(6, 2, 3, 0));
    wr(8'h70, winW(2, 4));
    wr(8'h20, perW(7, 3, 2, 1));
    idle(60);

    curReq = "R9";
    wr(8'h40, perW(8, 0, 3, 0));
    wr(8'h80, perW(6, 1, 2, 0));
    idle(40);

    curReq = "R11";
    wr(8'h08, 32'h1);
    wr(8'h20, perW(4, 2, 3, 0));
    idle(1);
    chk("R11 stopped idle level pin", 32'(pwmPin[0]), 32'h1);
    chk("R11 stopped idle level oe", 32'(pwmOe[0]), 32'h1);
    wr(8'h10, winW(1, 3));
    idle(3);
    wr(8'h04, 32'h1);
    idle(30);

    curReq = "R6";
    wr(8'h20, perW(0, 3, 2, 0));
    wr(8'h10, winW(0, 1));
    idle(15);
    wr(8'h20, perW(3, 3, 2, 0));
    wr(8'h10, winW(1, 2));
    idle(20);

    curReq = "R7";
    wr(8'h20, perW(8, 3, 2, 0));
    wr(8'h10, winW(5, 3));
    idle(30);
    wr(8'h10, winW(3, 6));
    idle(30);

    compareOn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule